// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block decides where each received frame byte lands in system memory. Software builds a ring of two-word descriptors in memory, points the block at the first one and turns reception on. When a frame starts, the walker reads the current descriptor and checks whether the buffer belongs to hardware. It then packs the incoming bytes into 32-bit words and writes them to the buffer. Each buffer takes at most 128 bytes, and a longer frame moves on to the next descriptor. When a buffer is finished, the walker returns it to software by rewriting its descriptor with status, length and the ownership flag.

The line side is a byte stream with start-of-frame and end-of-frame markers and a ready signal for backpressure. Memory is reached through a single-outstanding request/acknowledge port carrying whole words. A small register port sets the receive enable, a loop-back mode bit and the queue base pointer. A sticky flag reports frames that found no free buffer.

Top module: `rxw_ring_walker`

## Requirements
- R1: A buffer receives at most 128 bytes, and a longer frame continues in the next descriptor's buffer. Buffer byte k is written to byte lane k mod 4 (lane 0 = bits 7:0) of the word at buffer address + 4*(k/4). Unused upper lanes of a frame's last word are zero.
- R2: Descriptor number i sits at queue pointer + 8*i. Word 0 holds the buffer address in bits 31:2, the ownership flag in bit 0 (0 = hardware may fill) and the wrap flag in bit 1. Each buffer starts with a read of word 0.
- R3: After a descriptor whose wrap flag is 1, the next fetch is at the queue pointer. With no wrap flag set, the walker returns to the queue pointer after descriptor 1023.
- R4: Closing a buffer writes word 1 (at descriptor + 4) first and word 0 last. Word 0 is written back with bit 0 set to 1 and bits 31:1 as they were read.
- R5: Word 1 carries the frame length mod 4096 in bits 11:0 only in the descriptor that ends the frame (0 in the others). Bit 14 is 1 in the frame's first buffer, bit 15 is 1 in its last buffer, and all other bits are 0.
- R6: If a fetched word 0 has bit 0 = 1, the walker makes no write. It accepts and discards the rest of the frame up to its end marker, sets bna_o, and fetches the same descriptor for the next frame.
- R7: A queue pointer write (cfg_sel = 1) is ignored while reception is enabled. Bits 1:0 of the pointer are stored as zero.
- R8: A control write (cfg_sel = 0) always loads bit 0 as receive enable. Bit 1 (loop-back) is taken only when reception is currently disabled and the write leaves bit 0 at 0. Otherwise loop-back keeps its value.
- R9: Disabling reception moves the ring position back to the queue pointer. A control write that turns reception on from off clears bna_o.
- R10: While idle, bytes without a start marker are accepted and discarded without memory access. While disabled, all bytes are accepted and discarded without memory access.
- R11: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata stable until mem_ack. Only one request is outstanding at a time.
- R12: After reset, reception and loop-back are off, bna_o is 0 and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = queue pointer |
| cfg_wdata | input | 32 | Register write data |
| rx_en_o | output | 1 | Receive enable state |
| loopback_o | output | 1 | Loop-back mode state |
| bna_o | output | 1 | Sticky buffer-not-available flag |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte accepted at this clock edge when rx_valid is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 32 | Read data |

## Verification
The frame lengths are chosen to separate the packing and buffer-split paths. A 10-byte frame ends in a partial word, and a 4-byte frame fills exactly one word. A 128-byte frame fills one buffer exactly without spilling, and a 200-byte frame is split across two descriptors, the second of which carries the wrap flag. A run of 1025 one-byte frames through a ring with no wrap flag shows whether the walker comes back to the base on its own after 1024 descriptors. A descriptor left owned by software, register writes made while enabled, and stray or disabled-time bytes show whether the walker stays silent, keeps its position and ignores locked fields.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FILL,
        ST_WR_DATA,
        ST_WR_D1,
        ST_WR_D0,
        ST_DROP
    } rxw_state_e;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_LB_BIT   = 1;
    localparam int DSC_OWN_BIT  = 0;
    localparam int DSC_WRAP_BIT = 1;
    localparam int DW1_SOF_BIT  = 14;
    localparam int DW1_EOF_BIT  = 15;
endpackage

// File: rtl/rxw_cfg.sv
module rxw_cfg
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        walker_idle,
    output logic        en_o,
    output logic        lb_o,
    output logic [31:0] qptr_o,
    output logic        en_set_o
);
    typedef struct packed {
        logic        en;
        logic        lb;
        logic [31:0] qptr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        en_set_o = 1'b0;
        if (cfg_we) begin
            if (!cfg_sel) begin
                // loop-back only moves in a write that keeps the receiver off
                if (!cfg_q.en && !cfg_wdata[CTL_EN_BIT])
                    cfg_d.lb = cfg_wdata[CTL_LB_BIT];
                if (!cfg_q.en && cfg_wdata[CTL_EN_BIT])
                    en_set_o = 1'b1;
                cfg_d.en = cfg_wdata[CTL_EN_BIT];
            end else if (!cfg_q.en && walker_idle) begin
                cfg_d.qptr = cfg_wdata & 32'hFFFF_FFFC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o   = cfg_q.en;
    assign lb_o   = cfg_q.lb;
    assign qptr_o = cfg_q.qptr;

    AST_QPTR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> $stable(qptr_o)); // R7
    AST_LB_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> $stable(lb_o)); // R8
endmodule

// File: rtl/rxw_ring_idx.sv
module rxw_ring_idx #(
    parameter int RING_MAX = 1024,
    parameter int IDX_W    = $clog2(RING_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             wrap_hit,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_MAX - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clear)
            idx_d = '0;
        else if (advance)
            idx_d = (wrap_hit || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/rxw_ring_walker.sv
module rxw_ring_walker
    import rxw_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int RING_MAX  = 1024,
    parameter int LEN_W     = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        rx_en_o,
    output logic        loopback_o,
    output logic        bna_o,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam int IDX_W = $clog2(RING_MAX);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

    typedef struct packed {
        rxw_state_e       st;
        logic [31:0]      buf_base;
        logic             wrap;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] flen;
        logic [31:0]      word;
        logic             first;
        logic             last;
        logic             bna;
    } walk_t;

    walk_t w_d, w_q;

    logic             rx_en, en_set, ring_adv;
    logic [31:0]      qptr, desc_addr, word1;
    logic [IDX_W-1:0] ring_idx;
    logic [CNT_W-1:0] word_off;
    logic [1:0]       lane;

    rxw_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .walker_idle (w_q.st == ST_IDLE),
        .en_o        (rx_en),
        .lb_o        (loopback_o),
        .qptr_o      (qptr),
        .en_set_o    (en_set)
    );

    rxw_ring_idx #(.RING_MAX(RING_MAX), .IDX_W(IDX_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!rx_en && w_q.st == ST_IDLE),
        .advance  (ring_adv),
        .wrap_hit (w_q.wrap),
        .idx_o    (ring_idx)
    );

    assign desc_addr = qptr + 32'({ring_idx, 3'b000});
    assign lane      = w_q.cnt[1:0];
    assign word_off  = (w_q.cnt - 1'b1) & ~CNT_W'(3);

    always_comb begin
        word1                 = '0;
        word1[LEN_W-1:0]      = w_q.last ? w_q.flen : '0;
        word1[DW1_SOF_BIT]    = w_q.first;
        word1[DW1_EOF_BIT]    = w_q.last;
    end

    always_comb begin
        w_d       = w_q;
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ring_adv  = 1'b0;
        unique case (w_q.st)
            ST_IDLE: begin
                rx_ready = !(rx_en && rx_sof);
                if (rx_en && rx_valid && rx_sof) begin
                    w_d.st    = ST_FETCH;
                    w_d.first = 1'b1;
                    w_d.last  = 1'b0;
                    w_d.flen  = '0;
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr;
                if (mem_ack) begin
                    if (mem_rdata[DSC_OWN_BIT]) begin
                        w_d.bna = 1'b1;
                        w_d.st  = ST_DROP;
                    end else begin
                        w_d.buf_base = mem_rdata & 32'hFFFF_FFFC;
                        w_d.wrap     = mem_rdata[DSC_WRAP_BIT];
                        w_d.cnt      = '0;
                        w_d.word     = '0;
                        w_d.st       = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    w_d.word[{lane, 3'b000} +: 8] = rx_data;
                    w_d.cnt  = w_q.cnt + 1'b1;
                    w_d.flen = w_q.flen + 1'b1;
                    w_d.last = rx_eof;
                    if (rx_eof || lane == 2'd3) w_d.st = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = w_q.buf_base + 32'(word_off);
                mem_wdata = w_q.word;
                if (mem_ack) begin
                    w_d.word = '0;
                    w_d.st   = (w_q.last || w_q.cnt == CNT_FULL) ? ST_WR_D1 : ST_FILL;
                end
            end
            ST_WR_D1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + 32'd4;
                mem_wdata = word1;
                if (mem_ack) w_d.st = ST_WR_D0;
            end
            ST_WR_D0: begin
                // ownership handed back last, after status is in place
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = w_q.buf_base | (32'(w_q.wrap) << DSC_WRAP_BIT) | 32'd1;
                if (mem_ack) begin
                    ring_adv  = 1'b1;
                    w_d.first = 1'b0;
                    w_d.st    = w_q.last ? ST_IDLE : ST_FETCH;
                end
            end
            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_eof) w_d.st = ST_IDLE;
            end
            default: w_d.st = ST_IDLE;
        endcase
        if (!rx_en && (!mem_req || mem_ack)) w_d.st = ST_IDLE;
        if (en_set) w_d.bna = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign rx_en_o = rx_en;
    assign bna_o   = w_q.bna;

    AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cnt <= CNT_FULL); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata))); // R11
    AST_BNA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_FETCH && mem_ack && mem_rdata[DSC_OWN_BIT] && rx_en && !cfg_we)
        |=> $stable(ring_idx)); // R6
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bna_o && !$past(bna_o)) |-> !mem_req); // R6
endmodule

// File: tb/rxw_ring_walker_tb.sv
module rxw_ring_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_en_o, loopback_o, bna_o;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    rxw_ring_walker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_en_o(rx_en_o), .loopback_o(loopback_o), .bna_o(bna_o),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    localparam int unsigned BASE_A = 32'h0000_1000;
    localparam int unsigned BASE_B = 32'h0000_4000;

    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata <= rd(mem_addr);
        end else mem_ack <= 1'b0;
    end

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } item_t;
    item_t expq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: compare each completed memory access with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected memory access addr", mem_addr, 32'h0);
            end else begin
                item_t it;
                it = expq.pop_front();
                chk(mem_we == it.we && mem_addr == it.addr, it.tag, "access addr",
                    mem_addr, it.addr);
                if (it.we) chk(mem_wdata == it.data, it.tag, "write data", mem_wdata, it.data);
            end
        end
    end

    int  idx = 0;
    int unsigned base = BASE_A;

    function automatic logic [31:0] dinit(input int unsigned rb, input int i);
        if (rb == BASE_A) return 32'h0002_0000 + 32'(i) * 32'h100 | ((i == 3) ? 32'h2 : 32'h0);
        return 32'h0010_0000 + 32'(i) * 32'd128;
    endfunction

    task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d,
                        input string tag);
        item_t it;
        it.we = we; it.addr = a; it.data = d; it.tag = tag;
        expq.push_back(it);
    endtask

    task automatic cfg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_sof = s; rx_eof = e;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic wait_idle();
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input int seed);
        logic [7:0] bytes[];
        int unsigned used[$];
        int rem, off, chunk;
        bit first, last;
        int unsigned daddr;
        logic [31:0] w0, dw, w1;
        bytes = new[n];
        for (int k = 0; k < n; k++) bytes[k] = 8'(seed * 13 + k * 7 + 1);
        rem = n; off = 0; first = 1'b1;
        while (rem > 0) begin
            daddr = base + 32'(idx) * 8;
            w0 = rd(daddr);
            chunk = (rem > 128) ? 128 : rem;
            last = (rem == chunk);
            push(1'b0, daddr, 32'h0, "R2 R3 fetch");
            if (w0[0]) break;  // R6: owned by software, nothing written
            for (int w = 0; w < (chunk + 3) / 4; w++) begin
                dw = '0;
                for (int l = 0; l < 4; l++)
                    if (w * 4 + l < chunk) dw[l*8 +: 8] = bytes[off + w * 4 + l];
                push(1'b1, (w0 & 32'hFFFF_FFFC) + 32'(w) * 4, dw, "R1");
            end
            w1 = '0;
            if (last) w1[11:0] = n[11:0];
            w1[14] = first;
            w1[15] = last;
            push(1'b1, daddr + 4, w1, "R5");
            push(1'b1, daddr, w0 | 32'h1, "R4");
            used.push_back(daddr);
            idx = (w0[1] || idx == 1023) ? 0 : idx + 1;  // R3
            rem -= chunk; off += chunk; first = 1'b0;
        end
        for (int k = 0; k < n; k++) send_byte(bytes[k], k == 0, k == n - 1);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        wait_idle();
        foreach (used[u]) mem[used[u]] = rd(used[u]) & 32'hFFFF_FFFE;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            mem[BASE_A + 32'(i) * 8] = dinit(BASE_A, i);
            mem[BASE_A + 32'(i) * 8 + 4] = 32'h0;
        end
        for (int i = 0; i < 1024; i++) begin
            mem[BASE_B + 32'(i) * 8] = dinit(BASE_B, i);
            mem[BASE_B + 32'(i) * 8 + 4] = 32'h0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!rx_en_o, "R12", "rx_en_o", 32'(rx_en_o), 0);
        chk(!loopback_o, "R12", "loopback_o", 32'(loopback_o), 0);
        chk(!bna_o, "R12", "bna_o", 32'(bna_o), 0);
        chk(!mem_req, "R12", "mem_req", 32'(mem_req), 0);

        // R10 bytes while disabled
        send_frame_silent(5, 1'b1);
        cfg(1'b1, BASE_A);
        cfg(1'b0, 32'h1);
        chk(rx_en_o, "R8", "rx_en_o after enable", 32'(rx_en_o), 1);

        // R10 stray bytes with no start marker while idle
        send_frame_silent(3, 1'b0);

        send_frame(10, 1);    // partial last word, desc0
        send_frame(128, 2);   // exact buffer, desc1
        send_frame(200, 3);   // split over desc2 and desc3 (wrap flag)
        send_frame(4, 4);     // back at desc0
        chk(idx == 1, "R3", "bench ring position", 32'(idx), 1);

        // R6 descriptor owned by software
        mem[BASE_A + 8] = rd(BASE_A + 8) | 32'h1;
        send_frame(20, 5);
        chk(bna_o, "R6", "bna_o after owned descriptor", 32'(bna_o), 1);
        mem[BASE_A + 8] = rd(BASE_A + 8) & 32'hFFFF_FFFE;
        send_frame(5, 6);     // same descriptor fetched again (R6)

        // R7, R8 writes while enabled
        cfg(1'b1, BASE_B);
        cfg(1'b0, 32'h3);
        chk(!loopback_o, "R8", "loop-back while enabled", 32'(loopback_o), 0);
        send_frame(3, 7);     // still ring A (R7)

        cfg(1'b0, 32'h2);     // disable; bit1 ignored since enabled
        idx = 0;
        chk(!loopback_o && !rx_en_o, "R8", "disable write loop-back",
            32'({rx_en_o, loopback_o}), 0);
        chk(bna_o, "R9", "bna_o held while disabled", 32'(bna_o), 1);
        cfg(1'b0, 32'h2);
        chk(loopback_o, "R8", "loop-back set while disabled", 32'(loopback_o), 1);
        cfg(1'b1, BASE_B);
        base = BASE_B;
        cfg(1'b0, 32'h1);
        chk(loopback_o, "R8", "loop-back kept by enabling write", 32'(loopback_o), 1);
        chk(!bna_o, "R9", "bna_o cleared on enable", 32'(bna_o), 0);

        // R3 implicit return after 1024 descriptors
        for (int f = 0; f < 1025; f++) send_frame(1, f);
        chk(idx == 1, "R3", "bench ring position after 1025", 32'(idx), 1);

        // R9 disable resets the ring position
        cfg(1'b0, 32'h0);
        cfg(1'b0, 32'h1);
        idx = 0;
        send_frame(2, 9);

        cfg(1'b0, 32'h0);
        cfg(1'b0, 32'h0);
        chk(!loopback_o, "R8", "loop-back cleared while disabled", 32'(loopback_o), 0);
        chk(expq.size() == 0, "R11", "scoreboard drained", 32'(expq.size()), 0);
        done = 1'b1;
        summary();
        $finish;
    end

    // frame that must cause no memory access (R10)
    task automatic send_frame_silent(input int n, input bit with_sof);
        for (int k = 0; k < n; k++) send_byte(8'(k + 8'h40), with_sof && k == 0, k == n - 1);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (4) @(negedge clk);
        chk(!mem_req && expq.size() == 0, "R10", "no memory access for discarded bytes",
            32'(mem_req), 0);
    endtask
endmodule